// File: doc/BRIEF.md
# Embedded-Clock Serial Framer

This transmit-side block turns a parallel word into a self-clocking serial stream. The word is captured on a selectable edge of a word clock, wrapped with one high marker bit in front and one low marker bit behind, and shifted out as a 12-bit frame. The fast clock carries a bit enable that pulses twelve times per word period. That enable takes the place of the clock multiplier. A receiver can find the word grid because a low-to-high transition between the two marker bits appears in every frame.

On request the block sends synchronization frames in place of data. A sync frame is a run of ones followed by an equal run of zeros. Once a burst starts, it has a guaranteed minimum length. After reset, and again after each return from powerdown, the output stays undriven for a start-up interval counted in word-clock edges. An enable input, which stands in for a tri-state driver, and a powerdown input both gate the output-enable.

Top module: `ecf_serial_framer`

## Requirements
- R1: Every driven frame is 12 bits long. In send order, bit 0 is always 1 and bit 11 is always 0.
- R2: A data frame carries the captured word least-significant bit first in bits 1 to 10. The word is the one held in the capture register when the frame is loaded.
- R3: The serial output advances one bit per bit-enable pulse and holds between pulses. A new frame is loaded on every twelfth pulse.
- R4: A sync frame is bits 0 to 5 at 1 and bits 6 to 11 at 0, in send order.
- R5: The two sync request inputs are ORed. While the synchronized request is high at a frame boundary, a sync frame is loaded and no data frame is sent. A burst longer than the minimum lasts as many frames as there are boundaries that see the request.
- R6: A request that is seen at fewer than SYNC_MIN boundaries still produces exactly SYNC_MIN consecutive sync frames.
- R7: A switch between data and sync takes effect only at a frame boundary. Every frame that is driven in full is a well-formed data frame or a complete sync frame.
- R8: With edge_rise = 1 the parallel word is captured on the rising edge of word_clk, and with edge_rise = 0 on the falling edge.
- R9: After reset, ser_oe stays low until STARTUP_WORDS selected word-clock edges have been counted, and then rises at the next frame boundary with a start bit. Sync requests have no effect during this interval.
- R10: enable = 0 drops ser_oe in the same cycle while framing carries on. When enable returns, the output resumes on the unchanged frame grid.
- R11: pwr_on = 0 drops ser_oe in the same cycle and stops framing. When pwr_on returns, ser_oe stays low for a fresh start-up interval.
- R12: ser_out is 0 whenever ser_oe is 0. Under reset both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | 1 = powered, 0 = powerdown |
| enable | input | 1 | Output enable request, 1 = drive |
| bit_en | input | 1 | One pulse per serial bit, twelve per word period |
| word_clk | input | 1 | Word clock, sampled in the clk domain |
| edge_rise | input | 1 | 1 = capture on rising word_clk edge, 0 = falling |
| din | input | DATA_W | Parallel data word |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| ser_out | output | 1 | Serial bit, low when not driven |
| ser_oe | output | 1 | Output-enable for the serial driver |

## Verification
Data framing is driven with bit-enable pulses that stall at random and with random words. Directed all-zero, all-one and alternating words are added to these. Each word is held for three frames, and the decoded payload is compared against it, so a bit-order or marker error is told apart from plain capture latency. For edge selection, the word changes only in the cycle of the rising word-clock edge, so that a rising-edge capture and a falling-edge capture must decode to different values. For sync, a two-frame request on one input is compared against a 1300-frame request on the other, which separates the minimum-length rule from the follow-the-request rule. Enable and powerdown toggles are placed in the middle of a frame to show that the frame grid and the start-up count are kept or restarted as required.

// File: rtl/ecf_pkg.sv
package ecf_pkg;
   typedef enum logic [1:0] {
      FK_IDLE = 2'd0,
      FK_DATA = 2'd1,
      FK_SYNC = 2'd2
   } frame_kind_e;
endpackage

// File: rtl/ecf_word_capture.sv
module ecf_word_capture #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_clk,
   input  logic              edge_rise,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] cap_word,
   output logic              word_edge
);
   logic wclk_q;
   logic rise_seen;
   logic fall_seen;

   assign rise_seen = word_clk & ~wclk_q;
   assign fall_seen = ~word_clk & wclk_q;
   assign word_edge = edge_rise ? rise_seen : fall_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wclk_q   <= 1'b0;
         cap_word <= '0;
      end else begin
         wclk_q <= word_clk;
         if (word_edge) begin
            cap_word <= din;
         end
      end
   end
endmodule

// File: rtl/ecf_startup.sv
module ecf_startup #(
   parameter int STARTUP_WORDS = 510
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   input  logic word_edge,
   output logic ready
);
   generate
      if (STARTUP_WORDS == 0) begin : g_none
         assign ready = pwr_on;
      end else begin : g_count
         localparam int CW = $clog2(STARTUP_WORDS + 1);
         localparam logic [CW-1:0] LIMIT = CW'(STARTUP_WORDS);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!pwr_on) begin
               cnt <= '0;
            end else if (word_edge && (cnt != LIMIT)) begin
               cnt <= cnt + 1'b1;
            end
         end

         assign ready = pwr_on && (cnt == LIMIT);
      end
   endgenerate
endmodule

// File: rtl/ecf_sync_ctl.sv
module ecf_sync_ctl #(
   parameter int SYNC_MIN    = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   input  logic req_a,
   input  logic req_b,
   input  logic link_ready,
   input  logic frame_load,
   output logic sync_sel
);
   localparam int RW = $clog2(SYNC_MIN + 1);
   localparam logic [RW-1:0] FIRST_LEFT = RW'(SYNC_MIN - 1);

   logic [SYNC_STAGES-1:0] chain;
   logic                   req_s;
   logic [RW-1:0]          remain;
   logic                   in_burst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[SYNC_STAGES-2:0], req_a | req_b};
      end
   end

   assign req_s    = chain[SYNC_STAGES-1];
   assign sync_sel = link_ready && (req_s || (remain != '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain   <= '0;
         in_burst <= 1'b0;
      end else if (!pwr_on) begin
         remain   <= '0;
         in_burst <= 1'b0;
      end else if (frame_load) begin
         if (sync_sel) begin
            in_burst <= 1'b1;
            if (!in_burst) begin
               remain <= FIRST_LEFT;
            end else if (remain != '0) begin
               remain <= remain - 1'b1;
            end
         end else begin
            in_burst <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ecf_frame_shift.sv
module ecf_frame_shift
   import ecf_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on,
   input  logic              bit_en,
   input  frame_kind_e       kind,
   input  logic [DATA_W-1:0] data,
   output logic              frame_load,
   output logic              bit_out
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int HALF    = FRAME_W / 2;
   localparam int BW      = $clog2(FRAME_W);
   localparam logic [BW-1:0]      LAST     = BW'(FRAME_W - 1);
   localparam logic [FRAME_W-1:0] SYNC_PAT = {{HALF{1'b0}}, {HALF{1'b1}}};

   logic [BW-1:0]      bit_cnt;
   logic [FRAME_W-1:0] sh;

   assign frame_load = pwr_on && bit_en && (bit_cnt == LAST);
   assign bit_out    = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= LAST;
         sh      <= '0;
      end else if (!pwr_on) begin
         bit_cnt <= LAST;
         sh      <= '0;
      end else if (frame_load) begin
         bit_cnt <= '0;
         unique case (kind)
            FK_DATA: sh <= {1'b0, data, 1'b1};
            FK_SYNC: sh <= SYNC_PAT;
            default: sh <= '0;
         endcase
      end else if (bit_en) begin
         bit_cnt <= bit_cnt + 1'b1;
         sh      <= {1'b0, sh[FRAME_W-1:1]};
      end
   end
endmodule

// File: rtl/ecf_serial_framer.sv
module ecf_serial_framer
   import ecf_pkg::*;
#(
   parameter int DATA_W        = 10,
   parameter int STARTUP_WORDS = 510,
   parameter int SYNC_MIN      = 1024,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on,
   input  logic              enable,
   input  logic              bit_en,
   input  logic              word_clk,
   input  logic              edge_rise,
   input  logic [DATA_W-1:0] din,
   input  logic              sync_a,
   input  logic              sync_b,
   output logic              ser_out,
   output logic              ser_oe
);
   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("DATA_W must be even and at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 2");
      end
      if (SYNC_MIN < 1) begin : g_bad_min
         $error("SYNC_MIN must be at least 1");
      end
      if (STARTUP_WORDS < 0) begin : g_bad_start
         $error("STARTUP_WORDS must not be negative");
      end
   endgenerate

   logic [DATA_W-1:0] cap_word;
   logic              word_edge;
   logic              startup_ready;
   logic              sync_sel;
   logic              frame_load;
   logic              bit_out;
   logic              link_up;
   frame_kind_e       kind;

   ecf_word_capture #(.DATA_W(DATA_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_clk  (word_clk),
      .edge_rise (edge_rise),
      .din       (din),
      .cap_word  (cap_word),
      .word_edge (word_edge)
   );

   ecf_startup #(.STARTUP_WORDS(STARTUP_WORDS)) u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_on    (pwr_on),
      .word_edge (word_edge),
      .ready     (startup_ready)
   );

   ecf_sync_ctl #(.SYNC_MIN(SYNC_MIN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_on     (pwr_on),
      .req_a      (sync_a),
      .req_b      (sync_b),
      .link_ready (startup_ready),
      .frame_load (frame_load),
      .sync_sel   (sync_sel)
   );

   always_comb begin
      if (!startup_ready) begin
         kind = FK_IDLE;
      end else if (sync_sel) begin
         kind = FK_SYNC;
      end else begin
         kind = FK_DATA;
      end
   end

   ecf_frame_shift #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_on     (pwr_on),
      .bit_en     (bit_en),
      .kind       (kind),
      .data       (cap_word),
      .frame_load (frame_load),
      .bit_out    (bit_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_up <= 1'b0;
      end else if (!pwr_on) begin
         link_up <= 1'b0;
      end else if (frame_load) begin
         link_up <= startup_ready;
      end
   end

   assign ser_oe  = enable && pwr_on && link_up;
   assign ser_out = bit_out && ser_oe;
endmodule

// File: rtl/ecf_serial_framer_chk.sv
module ecf_serial_framer_chk #(
   parameter int DATA_W   = 10,
   parameter int SYNC_MIN = 1024
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_on,
   input logic bit_en,
   input logic ser_out,
   input logic ser_oe,
   input logic frame_load,
   input logic sync_sel,
   input logic link_ready
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int HALF    = FRAME_W / 2;
   localparam int IW      = $clog2(FRAME_W);
   localparam int CW      = $clog2(SYNC_MIN + 2);
   localparam logic [IW-1:0] LAST = IW'(FRAME_W - 1);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [IW-1:0] idx;
   logic          is_sync;
   logic [CW-1:0] burst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= LAST;
         is_sync <= 1'b0;
         burst   <= '0;
      end else if (!pwr_on) begin
         idx     <= LAST;
         is_sync <= 1'b0;
         burst   <= '0;
      end else if (frame_load) begin
         idx     <= '0;
         is_sync <= link_ready && sync_sel;
         if (link_ready && sync_sel) begin
            if (burst != CMAX) burst <= burst + 1'b1;
         end else begin
            burst <= '0;
         end
      end else if (bit_en && (idx != LAST)) begin
         idx <= idx + 1'b1;
      end
   end

   AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_load |-> (idx == LAST)); // R3
   AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_oe && (idx == '0)) |-> ser_out); // R1
   AST_STOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_oe && (idx == LAST)) |-> !ser_out); // R1
   AST_SYNC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_oe && is_sync) |-> (ser_out == (int'(idx) < HALF))); // R4
   AST_SYNC_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_load && link_ready && !sync_sel && (burst != '0)) |-> (int'(burst) >= SYNC_MIN)); // R6
   AST_DRIVE_AFTER_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
      ser_oe |-> link_ready); // R9
   AST_POWER_RETURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_on) |=> !ser_oe); // R11
endmodule

bind ecf_serial_framer ecf_serial_framer_chk #(
   .DATA_W   (DATA_W),
   .SYNC_MIN (SYNC_MIN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_on     (pwr_on),
   .bit_en     (bit_en),
   .ser_out    (ser_out),
   .ser_oe     (ser_oe),
   .frame_load (frame_load),
   .sync_sel   (sync_sel),
   .link_ready (startup_ready)
);

// File: tb/tb_ecf_serial_framer.sv
module tb_ecf_serial_framer;
   localparam int DW      = 10;
   localparam int FW      = DW + 2;
   localparam int STARTUP = 510;
   localparam int SMIN    = 1024;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, pwr_on, enable, bit_en, word_clk, edge_rise, sync_a, sync_b;
   logic [DW-1:0] din;
   logic          ser_out, ser_oe;

   ecf_serial_framer #(.DATA_W(DW), .STARTUP_WORDS(STARTUP), .SYNC_MIN(SMIN)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .enable(enable), .bit_en(bit_en),
      .word_clk(word_clk), .edge_rise(edge_rise), .din(din), .sync_a(sync_a),
      .sync_b(sync_b), .ser_out(ser_out), .ser_oe(ser_oe)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   int phase = FW - 1, edges = 0, bit_drv = 0;
   bit linked = 0;
   int idx = 0;
   logic [FW-1:0] fbits;
   bit fvalid = 0;
   int sync_run = 0, last_burst = 0, bursts = 0;
   int bad_frame = 0, bad_data = 0, data_in_sync = 0, zero_viol = 0, oe_viol = 0;
   int frames_all = 0;
   int mode = 0;
   bit dchk = 0, req_settled = 0, match_cur = 0;
   logic [DW-1:0] cur = '0, prev = '0, wa = 10'h0F0, wb = 10'h30C;
   int good_e = 0, bad_e = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pick_word();
      logic [DW-1:0] w;
      w = DW'($urandom_range(1023));
      if (w == 10'h01F) w = 10'h01E; // would look like a sync frame
      return w;
   endfunction

   task automatic classify();
      logic [DW-1:0] w;
      w = fbits[FW-2:1];
      if (fbits == 12'h03F) begin
         sync_run++;
      end else begin
         if (sync_run != 0) begin
            last_burst = sync_run;
            bursts++;
            sync_run = 0;
         end
         if (!(fbits[0] && !fbits[FW-1])) begin
            bad_frame++;
         end else begin
            if (req_settled) data_in_sync++;
            if (mode == 0) begin
               if (dchk) begin
                  if (w == cur) match_cur = 1;
                  else if (w != prev) bad_data++;
               end
            end else begin
               if (w == (edge_rise ? wb : wa)) good_e++;
               else bad_e++;
            end
         end
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (!ser_oe && ser_out) zero_viol++;
      if (!enable && ser_oe) oe_viol++;
      if (rst_n && pwr_on) begin
         if (!linked) begin
            if (ser_oe) begin
               linked = 1;
               idx = 0;
               fbits = '0;
               fbits[0] = ser_out;
               fvalid = 1;
            end
         end else if (bit_en) begin
            idx = (idx == FW - 1) ? 0 : idx + 1;
            if (idx == 0) begin
               fbits = '0;
               fvalid = 1;
            end
            fbits[idx] = ser_out;
            if (!ser_oe) fvalid = 0;
            if (idx == FW - 1) begin
               frames_all++;
               if (fvalid) classify();
            end
         end
      end
      bit_en = ($urandom_range(3) != 0);
      if (bit_en) begin
         bit_drv++;
         phase = (phase + 1) % FW;
         if (phase == 0) edges++;
      end
      word_clk = (phase < FW / 2);
      din = (mode == 0) ? cur : ((phase == 0) ? wb : wa);
   endtask

   task automatic run_bits(input int n);
      int s;
      s = bit_drv;
      while (bit_drv - s < n) step();
   endtask

   task automatic hold_word(input logic [DW-1:0] w, input string req);
      prev = cur;
      cur = w;
      match_cur = 0;
      run_bits(3 * FW);
      chk(match_cur, req, 0, int'(w));
   endtask

   task automatic wait_link(input string req);
      while (!linked && edges < STARTUP + 20) step();
      chk(linked && edges >= STARTUP - 1 && edges <= STARTUP + 2, req, edges, STARTUP);
   endtask

   initial begin
      void'($urandom(32'd4242));
      rst_n = 0; pwr_on = 1; enable = 1; bit_en = 0; word_clk = 0; edge_rise = 1;
      sync_a = 0; sync_b = 0; din = '0;
      repeat (5) step();
      chk(!ser_oe && !ser_out, "R12", int'(ser_oe), 0);
      @(negedge clk);
      rst_n = 1;
      edges = 0;
      // request during start-up must not matter
      sync_a = 1;
      run_bits(24);
      sync_a = 0;
      wait_link("R9");
      chk(ser_out == 1'b1, "R1", int'(ser_out), 1);

      // directed and random data words
      dchk = 1;
      hold_word(10'h000, "R2");
      hold_word(10'h3FF, "R2");
      hold_word(10'h155, "R2");
      hold_word(10'h2AA, "R2");
      hold_word(10'h001, "R2");
      hold_word(10'h200, "R2");
      for (int i = 0; i < 30; i++) hold_word(pick_word(), "R2");
      chk(sync_run == 0 && bursts == 0, "R9", bursts, 0);

      // frame rate: 360 bit pulses give 30 frames
      begin
         int f0;
         f0 = frames_all;
         run_bits(30 * FW);
         chk(frames_all - f0 >= 29 && frames_all - f0 <= 31, "R3", frames_all - f0, 30);
      end

      // edge selection
      dchk = 0;
      mode = 1;
      edge_rise = 1;
      run_bits(4 * FW);
      good_e = 0; bad_e = 0;
      run_bits(20 * FW);
      chk(bad_e == 0 && good_e >= 15, "R8", bad_e, 0);
      edge_rise = 0;
      run_bits(4 * FW);
      good_e = 0; bad_e = 0;
      run_bits(20 * FW);
      chk(bad_e == 0 && good_e >= 15, "R8", bad_e, 0);
      edge_rise = 1;
      mode = 0;
      cur = 10'h123;
      run_bits(4 * FW);
      dchk = 1;
      hold_word(10'h0A5, "R2");

      // short request on the first input
      begin
         int b0;
         b0 = bursts;
         sync_a = 1;
         run_bits(2 * FW);
         sync_a = 0;
         while (bursts == b0) step();
         chk(last_burst == SMIN, "R6", last_burst, SMIN);
      end
      hold_word(10'h2C3, "R7");

      // long request on the second input
      begin
         int b0;
         b0 = bursts;
         sync_b = 1;
         run_bits(2 * FW);
         req_settled = 1;
         run_bits(1300 * FW - 2 * FW);
         req_settled = 0;
         sync_b = 0;
         while (bursts == b0) step();
         chk(last_burst >= 1299 && last_burst <= 1301, "R5", last_burst, 1300);
         chk(last_burst >= 1299 && last_burst <= 1301, "R3", last_burst, 1300);
         chk(data_in_sync == 0, "R5", data_in_sync, 0);
      end
      hold_word(10'h19E, "R7");
      chk(bad_frame == 0, "R7", bad_frame, 0);

      // tri-state toggle mid-frame
      run_bits(5);
      enable = 0;
      run_bits(30);
      chk(oe_viol == 0 && !ser_oe, "R10", oe_viol, 0);
      enable = 1;
      begin
         int bf;
         bf = bad_frame;
         hold_word(10'h0C7, "R10");
         hold_word(10'h338, "R10");
         chk(bad_frame == bf, "R10", bad_frame - bf, 0);
      end

      // powerdown mid-frame and restart with falling edge
      run_bits(7);
      pwr_on = 0;
      step();
      chk(!ser_oe, "R11", int'(ser_oe), 0);
      linked = 0;
      sync_run = 0;
      repeat (40) step();
      chk(!ser_oe && !ser_out, "R11", int'(ser_oe), 0);
      edge_rise = 0;
      pwr_on = 1;
      edges = 0;
      step();
      chk(!ser_oe, "R11", int'(ser_oe), 0);
      wait_link("R11");
      hold_word(pick_word(), "R2");
      hold_word(pick_word(), "R2");

      chk(zero_viol == 0, "R12", zero_viol, 0);
      chk(bad_frame == 0, "R1", bad_frame, 0);
      chk(bad_data == 0, "R2", bad_data, 0);
      chk(sync_run == 0, "R4", sync_run, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule